// File: doc/BRIEF.md
# Two-Stage Configurable Permutation Router

This block is the routing fabric between a square array of K×K processing-element ports and a K×K array of check-unit ports in a partly parallel iterative decoder. Every clock cycle it moves one word from each processing element to a check-unit port, and moves one reply from each check-unit port back to the processing element the request came from. The forward words are FW bits wide, a hard-decision bit on top of a message. The return words are RW bits wide and travel on their own wires.

Routing is done in two cascaded stages. The first stage reorders the K words inside each row. The second reorders the K words inside each column. Every row and every column switch chooses between the identity and one fixed pseudo-random permutation of its own. The choice is made by one control bit per switch, and the control bits change every cycle. Two constant tables of L words each supply them, addressed by a phase counter. The return path undoes both stages in reverse order. It uses the control words of three cycles earlier, which matches the latency of the external datapath loop. The permutations and both tables are elaboration-time constants, derived from the SEED parameter by the functions in the package.

Top module: `shuffle2d_router`

## Requirements
- R1: Port p = x*K+y holds word (x,y) at bits [p*W +: W], where x is the row and y is the column. When bit x of the active row control word is 1, the row stage output (x,y) takes input (x, Rx(y)). When that bit is 0, it takes input (x,y). Rx is row x's fixed permutation.
- R2: A switch whose control bit is 0 passes its words unchanged. When both return control words are zero, which holds for the three cycles after reset, ret_out equals ret_in.
- R3: When bit y of the active column control word is 1, the column stage output (x,y) takes stage-one word (Cy(x), y). When that bit is 0, it takes (x,y). Check unit x receives ports x*K through x*K+K-1.
- R4: The control words come from the two tables at the phase address. The address is 0 after reset. It is 0 in the cycle after start is high. Otherwise it advances by one each cycle and wraps from L-1 to 0.
- R5: The return path uses the row and column control words that the forward path used exactly three cycles earlier. Before that, it uses zero.
- R6: The return path first applies the inverse column permutation and then the inverse row permutation. A message entering check-unit port q leaves at the processing-element port whose forward word was routed to q under the delayed controls.
- R7: Each forward word carries its message in bits [RW-1:0] and its hard-decision bit in bit FW-1. Feeding the message fields of fwd_out back into ret_in three cycles later makes ret_out equal to the message fields of that earlier fwd_in.
- R8: A word never leaves its row in the row stage or its column in the column stage. With the column word zero, the XOR of each output row equals the XOR of the same input row. With the row word zero, the same holds for each column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restarts the phase address at 0 from the next cycle |
| fwd_in | input | K*K*FW | Words from the processing elements |
| fwd_out | output | K*K*FW | Routed words to the check-unit ports |
| ret_in | input | K*K*RW | Replies from the check-unit ports |
| ret_out | output | K*K*RW | Replies routed back to the processing elements |

## Verification
The bench drives random data through every table entry and past the wrap from L-1 to 0. It restarts the phase mid-run, which catches a counter that ignores start or restarts one cycle late: such a design would route with the wrong table row. Replies are checked two ways. Random replies are compared against a scatter model of the inverse route. Looped-back forward messages must return to their origin, so a wrong delay depth, inverse stages applied in the wrong order, or a missing inverse would send messages to the wrong elements. The three cycles after reset, when the return controls must be zero, catch delay registers that reset to anything else.

// File: rtl/shuf2d_pkg.sv
`timescale 1ns/1ps
package shuf2d_pkg;
    localparam int MAX_K   = 16;
    localparam int COL_SEL = 64;

    function automatic int unsigned mix32(input int unsigned v);
        int unsigned t;
        t = v ^ (v >> 15);
        t = t * 32'h2C1B3C6D;
        t = t ^ (t >> 12);
        t = t * 32'h297A2D39;
        t = t ^ (t >> 15);
        return t;
    endfunction

    // Source index of position idx under switch sel's fixed permutation
    function automatic int perm_src(input int unsigned seed, input int sel,
                                    input int idx, input int k);
        int p [MAX_K];
        int unsigned st;
        int j;
        int t;
        for (int i = 0; i < MAX_K; i++) p[i] = i;
        st = mix32(seed ^ (32'(sel) * 32'h9E3779B9));
        for (int i = k - 1; i > 0; i--) begin
            st   = mix32(st + 32'(i));
            j    = int'(st % 32'(i + 1));
            t    = p[i];
            p[i] = p[j];
            p[j] = t;
        end
        return p[idx];
    endfunction

    function automatic int perm_inv(input int unsigned seed, input int sel,
                                    input int idx, input int k);
        int r;
        r = idx;
        for (int j = 0; j < k; j++)
            if (perm_src(seed, sel, j, k) == idx) r = j;
        return r;
    endfunction

    // tbl 0: row controls, tbl 1: column controls
    function automatic logic [MAX_K-1:0] ctrl_word(input int unsigned seed, input int tbl,
                                                   input int addr, input int k);
        logic [MAX_K-1:0] w;
        int unsigned h;
        w = '0;
        for (int b = 0; b < k; b++) begin
            h    = mix32(seed ^ mix32(32'(tbl) * 32'd1000003 + 32'(addr) * 32'd131 + 32'(b)));
            w[b] = h[7];
        end
        return w;
    endfunction
endpackage

// File: rtl/shuf2d_stage.sv
`timescale 1ns/1ps
module shuf2d_stage #(
    parameter int          K       = 3,
    parameter int          W       = 6,
    parameter bit          COLUMN  = 1'b0,
    parameter bit          INVERSE = 1'b0,
    parameter int unsigned SEED    = 32'd1
) (
    input  logic [K-1:0]     sel,
    input  logic [K*K*W-1:0] din,
    output logic [K*K*W-1:0] dout
);
    import shuf2d_pkg::*;

    for (genvar g = 0; g < K; g++) begin : g_grp
        localparam int SEL_ID = COLUMN ? (COL_SEL + g) : g;
        for (genvar i = 0; i < K; i++) begin : g_pos
            localparam int SRC  = INVERSE ? perm_inv(SEED, SEL_ID, i, K)
                                          : perm_src(SEED, SEL_ID, i, K);
            localparam int OWN  = COLUMN ? (i * K + g)   : (g * K + i);
            localparam int FROM = COLUMN ? (SRC * K + g) : (g * K + SRC);
            assign dout[OWN*W +: W] = sel[g] ? din[FROM*W +: W] : din[OWN*W +: W];
        end
    end
endmodule

// File: rtl/shuf2d_ctrl.sv
`timescale 1ns/1ps
module shuf2d_ctrl #(
    parameter int          K       = 3,
    parameter int          L       = 8,
    parameter int          RET_DLY = 3,
    parameter int unsigned SEED    = 32'd1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    output logic [K-1:0] fwd_row,
    output logic [K-1:0] fwd_col,
    output logic [K-1:0] ret_row,
    output logic [K-1:0] ret_col
);
    import shuf2d_pkg::*;

    localparam int AW = (L > 1) ? $clog2(L) : 1;

    typedef struct packed {
        logic [AW-1:0]               cnt;
        logic [RET_DLY-1:0][K-1:0]   rdly;
        logic [RET_DLY-1:0][K-1:0]   cdly;
    } ctrl_st_t;

    logic [K-1:0] row_tab [L];
    logic [K-1:0] col_tab [L];

    for (genvar a = 0; a < L; a++) begin : g_tab
        localparam logic [MAX_K-1:0] RW_C = ctrl_word(SEED, 0, a, K);
        localparam logic [MAX_K-1:0] CW_C = ctrl_word(SEED, 1, a, K);
        assign row_tab[a] = RW_C[K-1:0];
        assign col_tab[a] = CW_C[K-1:0];
    end

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        fwd_row = row_tab[st_q.cnt];
        fwd_col = col_tab[st_q.cnt];
        if (start || st_q.cnt == AW'(L - 1)) st_d.cnt = '0;
        else                                 st_d.cnt = st_q.cnt + 1'b1;
        st_d.rdly[0] = fwd_row;
        st_d.cdly[0] = fwd_col;
        for (int s = 1; s < RET_DLY; s++) begin
            st_d.rdly[s] = st_q.rdly[s-1];
            st_d.cdly[s] = st_q.cdly[s-1];
        end
        ret_row = st_q.rdly[RET_DLY-1];
        ret_col = st_q.cdly[RET_DLY-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/shuffle2d_router.sv
`timescale 1ns/1ps
module shuffle2d_router #(
    parameter int          K    = 3,
    parameter int          L    = 8,
    parameter int          FW   = 6,
    parameter int          RW   = 5,
    parameter int unsigned SEED = 32'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [K*K*FW-1:0] fwd_in,
    output logic [K*K*FW-1:0] fwd_out,
    input  logic [K*K*RW-1:0] ret_in,
    output logic [K*K*RW-1:0] ret_out
);
    localparam int RET_DLY = 3;

    logic [K-1:0]      fwd_row, fwd_col, ret_row, ret_col;
    logic [K*K*FW-1:0] fwd_mid;
    logic [K*K*RW-1:0] ret_mid;

    shuf2d_ctrl #(.K(K), .L(L), .RET_DLY(RET_DLY), .SEED(SEED)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .fwd_row(fwd_row), .fwd_col(fwd_col),
        .ret_row(ret_row), .ret_col(ret_col)
    );

    shuf2d_stage #(.K(K), .W(FW), .COLUMN(1'b0), .INVERSE(1'b0), .SEED(SEED)) u_fwd_row (
        .sel(fwd_row), .din(fwd_in), .dout(fwd_mid)
    );
    shuf2d_stage #(.K(K), .W(FW), .COLUMN(1'b1), .INVERSE(1'b0), .SEED(SEED)) u_fwd_col (
        .sel(fwd_col), .din(fwd_mid), .dout(fwd_out)
    );

    shuf2d_stage #(.K(K), .W(RW), .COLUMN(1'b1), .INVERSE(1'b1), .SEED(SEED)) u_ret_col (
        .sel(ret_col), .din(ret_in), .dout(ret_mid)
    );
    shuf2d_stage #(.K(K), .W(RW), .COLUMN(1'b0), .INVERSE(1'b1), .SEED(SEED)) u_ret_row (
        .sel(ret_row), .din(ret_mid), .dout(ret_out)
    );
endmodule

// File: rtl/shuf2d_checker.sv
`timescale 1ns/1ps
module shuf2d_checker #(
    parameter int K  = 3,
    parameter int FW = 6,
    parameter int RW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [K*K*FW-1:0] fwd_in,
    input logic [K*K*FW-1:0] fwd_out,
    input logic [K*K*RW-1:0] ret_in,
    input logic [K*K*RW-1:0] ret_out,
    input logic [K-1:0]      fwd_row,
    input logic [K-1:0]      fwd_col,
    input logic [K-1:0]      ret_row,
    input logic [K-1:0]      ret_col
);
    logic [1:0] seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)             seen_q <= '0;
        else if (seen_q != 2'd3) seen_q <= seen_q + 1'b1;
    end

    logic [K*K*RW-1:0] msg_in, msg_out;
    for (genvar p = 0; p < K*K; p++) begin : g_msg
        assign msg_in[p*RW +: RW]  = fwd_in[p*FW +: RW];
        assign msg_out[p*RW +: RW] = fwd_out[p*FW +: RW];
    end

    logic [K-1:0][FW-1:0] rx_i, rx_o, cx_i, cx_o;
    always_comb begin
        rx_i = '0; rx_o = '0; cx_i = '0; cx_o = '0;
        for (int x = 0; x < K; x++)
            for (int y = 0; y < K; y++) begin
                rx_i[x] = rx_i[x] ^ fwd_in[(x*K+y)*FW +: FW];
                rx_o[x] = rx_o[x] ^ fwd_out[(x*K+y)*FW +: FW];
                cx_i[y] = cx_i[y] ^ fwd_in[(x*K+y)*FW +: FW];
                cx_o[y] = cx_o[y] ^ fwd_out[(x*K+y)*FW +: FW];
            end
    end

    assert_ret_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3) |-> (ret_row == $past(fwd_row, 3) && ret_col == $past(fwd_col, 3)));

    assert_ret_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q != 2'd3) |-> (ret_row == '0 && ret_col == '0));

    assert_fwd_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_row == '0 && fwd_col == '0) |-> (fwd_out == fwd_in));

    assert_ret_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_row == '0 && ret_col == '0) |-> (ret_out == ret_in));

    assert_round_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == 2'd3 && ret_in == $past(msg_out, 3)) |-> (ret_out == $past(msg_in, 3)));

    for (genvar g = 0; g < K; g++) begin : g_keep
        assert_row_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (fwd_col == '0) |-> (rx_o[g] == rx_i[g]));
        assert_col_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (fwd_row == '0) |-> (cx_o[g] == cx_i[g]));
    end
endmodule

bind shuffle2d_router shuf2d_checker #(.K(K), .FW(FW), .RW(RW)) u_chk (
    .clk(clk), .rst_n(rst_n), .fwd_in(fwd_in), .fwd_out(fwd_out),
    .ret_in(ret_in), .ret_out(ret_out), .fwd_row(fwd_row), .fwd_col(fwd_col),
    .ret_row(ret_row), .ret_col(ret_col)
);

// File: tb/tb_shuffle2d_router.sv
`timescale 1ns/1ps
module tb_shuffle2d_router;
    import shuf2d_pkg::*;

    localparam int          K    = 3;
    localparam int          L    = 8;
    localparam int          FW   = 6;
    localparam int          RW   = 5;
    localparam int unsigned SEED = 32'd7;
    localparam int          NF   = K*K*FW;
    localparam int          NR   = K*K*RW;
    localparam int          NCYC = 44;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NF-1:0] fwd_in = '0;
    logic [NF-1:0] fwd_out;
    logic [NR-1:0] ret_in = '0;
    logic [NR-1:0] ret_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    shuffle2d_router #(.K(K), .L(L), .FW(FW), .RW(RW), .SEED(SEED)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fwd_in(fwd_in), .fwd_out(fwd_out),
        .ret_in(ret_in), .ret_out(ret_out)
    );

    function automatic logic [K-1:0] tab(input int tbl, input int addr);
        logic [MAX_K-1:0] w;
        w = ctrl_word(SEED, tbl, addr, K);
        return w[K-1:0];
    endfunction

    // Forward route by definition: gather per row, then per column
    function automatic logic [NF-1:0] mdl_fwd(input logic [NF-1:0] a,
                                              input logic [K-1:0] rw, input logic [K-1:0] cw);
        logic [NF-1:0] b, c;
        for (int x = 0; x < K; x++)
            for (int y = 0; y < K; y++) begin
                int s;
                s = perm_src(SEED, x, y, K);
                b[(x*K+y)*FW +: FW] = rw[x] ? a[(x*K+s)*FW +: FW] : a[(x*K+y)*FW +: FW];
            end
        for (int x = 0; x < K; x++)
            for (int y = 0; y < K; y++) begin
                int s;
                s = perm_src(SEED, COL_SEL + y, x, K);
                c[(x*K+y)*FW +: FW] = cw[y] ? b[(s*K+y)*FW +: FW] : b[(x*K+y)*FW +: FW];
            end
        return c;
    endfunction

    // Return route: scatter each message back along the forward path
    function automatic logic [NR-1:0] mdl_ret(input logic [NR-1:0] m,
                                              input logic [K-1:0] rw, input logic [K-1:0] cw);
        logic [NR-1:0] b, a;
        for (int x = 0; x < K; x++)
            for (int y = 0; y < K; y++) begin
                int s;
                s = cw[y] ? perm_src(SEED, COL_SEL + y, x, K) : x;
                b[(s*K+y)*RW +: RW] = m[(x*K+y)*RW +: RW];
            end
        for (int x = 0; x < K; x++)
            for (int y = 0; y < K; y++) begin
                int s;
                s = rw[x] ? perm_src(SEED, x, y, K) : y;
                a[(x*K+s)*RW +: RW] = b[(x*K+y)*RW +: RW];
            end
        return a;
    endfunction

    function automatic logic [NR-1:0] msg_of(input logic [NF-1:0] v);
        logic [NR-1:0] r;
        for (int p = 0; p < K*K; p++) r[p*RW +: RW] = v[p*FW +: RW];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [NF-1:0] act, input logic [NF-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [NF-1:0] rnd_word();
        logic [NF-1:0] v;
        for (int p = 0; p < K*K; p++) v[p*FW +: FW] = FW'($urandom);
        return v;
    endfunction

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int            addr;
        logic [K-1:0]  rw, cw;
        logic [K-1:0]  rwh [3];
        logic [K-1:0]  cwh [3];
        logic [NF-1:0] inh [3];
        logic [NF-1:0] outh [3];
        for (int i = 0; i < 3; i++) begin
            rwh[i] = '0; cwh[i] = '0; inh[i] = '0; outh[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        addr  = 0;
        for (int n = 0; n < NCYC; n++) begin
            logic loop_back;
            // Data patterns: index-coded, all ones, then random
            if (n == 0) begin
                for (int p = 0; p < K*K; p++) fwd_in[p*FW +: FW] = FW'(p + 1);
            end else if (n == 1) fwd_in = '1;
            else                 fwd_in = rnd_word();
            loop_back = (n >= 3) && (n % 2 == 0);
            ret_in    = loop_back ? msg_of(outh[2]) : NR'(rnd_word());
            start     = (n == 13);
            rw        = tab(0, addr);
            cw        = tab(1, addr);
            #1;
            chk($sformatf("R1/R3/R4 fwd cycle %0d addr %0d", n, addr), fwd_out, mdl_fwd(fwd_in, rw, cw));
            chk($sformatf("R5/R6 ret cycle %0d", n), NF'(ret_out), NF'(mdl_ret(ret_in, rwh[2], cwh[2])));
            if (n < 3)
                chk($sformatf("R2 ret pass-through after reset cycle %0d", n), NF'(ret_out), NF'(ret_in));
            if (loop_back)
                chk($sformatf("R7 round trip cycle %0d", n), NF'(ret_out), NF'(msg_of(inh[2])));
            if (cw == '0) begin
                for (int x = 0; x < K; x++) begin
                    logic [FW-1:0] xi, xo;
                    xi = '0; xo = '0;
                    for (int y = 0; y < K; y++) begin
                        xi ^= fwd_in[(x*K+y)*FW +: FW];
                        xo ^= fwd_out[(x*K+y)*FW +: FW];
                    end
                    chk($sformatf("R8 row %0d kept cycle %0d", x, n), NF'(xo), NF'(xi));
                end
            end
            for (int i = 2; i > 0; i--) begin
                rwh[i] = rwh[i-1]; cwh[i] = cwh[i-1]; inh[i] = inh[i-1]; outh[i] = outh[i-1];
            end
            rwh[0] = rw; cwh[0] = cw; inh[0] = fwd_in; outh[0] = fwd_out;
            addr = start ? 0 : (addr + 1) % L;
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule